// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block is the priority core of a processor-local interrupt controller. It keeps three bit sets across the full vector space: pending requests, vectors in service, and the trigger kind of each vector. From these sets and a task priority value it works out a processor priority. It then decides whether the highest pending request may be signalled to the core on a registered interrupt line.

The core acknowledges with a strobe and reads the answer in the same cycle. The answer is the granted vector, a programmable spurious vector when the pending request is held off by priority, or a "none" flag. A grant moves the vector from pending to in service. An end-of-interrupt strobe retires the highest in-service vector. When that vector was level-triggered, and the suppress control is low, a one-cycle broadcast pulse carries the vector out to the request sources. The block does no address decoding and no destination routing.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the pending, in-service and trigger sets are empty, the task priority is 0x00 and the spurious register is 0x0FF (software enable bit 8 clear, spurious vector 0xFF). The interrupt line and the broadcast pulse are low.
- R2: A request strobe sets the pending bit of its vector. The vector's trigger bit is set for a level request and cleared for an edge request, and the most recent request decides.
- R3: The highest pending vector and the highest in-service vector are the highest-numbered set bits of their sets.
- R4: The processor priority equals the task priority when task priority bits [7:4] are at least the class (bits [7:4]) of the highest in-service vector. Otherwise it equals that class followed by four zero bits. An empty in-service set counts as class 0.
- R5: A pending request may be signalled only when the processor priority is 0x00, or when the class of the highest pending vector is strictly above the class of the processor priority.
- R6: The interrupt line is registered. It reflects the state one clock after that state changes.
- R7: An acknowledge that finds a signallable request returns the highest pending vector, clears its pending bit and sets its in-service bit. A request for the same vector in the same cycle leaves it pending.
- R8: An acknowledge while a request is pending but blocked returns bits [7:0] of the spurious register and changes no state. With nothing pending, or with software enable clear, it raises the none flag, returns vector 0 and changes no state.
- R9: End-of-interrupt clears the highest in-service bit. With nothing in service it has no effect.
- R10: When the retired vector's trigger bit is set and the suppress input is low, the broadcast output pulses for exactly one cycle, after the end-of-interrupt edge, carrying that vector. Otherwise it stays low.
- R11: While bit 8 of the spurious register is clear, the interrupt line stays low whatever is pending.
- R12: A write through the 4-bit path stores its value in task priority bits [7:4] with zeros below. The 4-bit read returns task priority bits [7:4]. A full 8-bit write stores the byte and takes precedence over the 4-bit path.
- R13: An acknowledge and an end-of-interrupt in the same cycle are processed acknowledge first, so the end-of-interrupt may retire the vector just granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| req_vec_i | input | 8 | Requested vector |
| req_level_i | input | 1 | 1 = level-triggered request, 0 = edge |
| ack_i | input | 1 | Acknowledge strobe from the core |
| ack_vec_o | output | 8 | Vector returned to a same-cycle acknowledge |
| ack_none_o | output | 1 | Acknowledge would find no deliverable or spurious answer |
| eoi_i | input | 1 | End-of-interrupt strobe |
| eoi_suppress_i | input | 1 | Suppresses the end-of-interrupt broadcast |
| tpr_wr_i | input | 1 | Full task priority write strobe |
| tpr_wdata_i | input | 8 | Full task priority write value |
| cr_wr_i | input | 1 | 4-bit task priority write strobe |
| cr_wdata_i | input | 4 | 4-bit task priority write value |
| cr_rdata_o | output | 4 | Task priority bits [7:4] |
| svr_wr_i | input | 1 | Spurious register write strobe |
| svr_wdata_i | input | 9 | Spurious register value: bit 8 software enable, bits [7:0] spurious vector |
| irq_o | output | 1 | Registered interrupt line to the core |
| eoi_bcast_o | output | 1 | One-cycle end-of-interrupt broadcast pulse |
| eoi_bcast_vec_o | output | 8 | Vector carried by the broadcast |

## Verification
On every cycle the assertions check the local effects: a request lands in the pending and trigger sets, a grant moves its vector into service, a blocked acknowledge leaves both sets untouched, end-of-interrupt clears the top in-service bit, and the broadcast only follows an unsuppressed end-of-interrupt of a level vector. The interrupt line is also checked against the software enable bit. The priority arithmetic, which decides which vector wins and whether it may be signalled, is only visible through the bench's scenarios. These sweep every vector through a full request, acknowledge and retire cycle, and cover the task-priority class against the request class in all combinations. They also cover in-service masking, and the ordering of same-cycle acknowledge, end-of-interrupt and re-request.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

   // How the acknowledge port answers in the current cycle
   typedef enum logic [1:0] {
      ACK_NONE     = 2'd0,
      ACK_SPURIOUS = 2'd1,
      ACK_GRANT    = 2'd2
   } ack_kind_e;

endpackage

// File: rtl/irq_top_find.sv
// Highest-numbered set bit of a wide vector, searched word by word.
module irq_top_find #(
   parameter int unsigned NUM_VEC = 256,
   parameter int unsigned WORD_W  = 32
) (
   input  logic [NUM_VEC-1:0]         bits_i,
   output logic                       found_o,
   output logic [$clog2(NUM_VEC)-1:0] idx_o
);

   localparam int unsigned IDX_W     = $clog2(NUM_VEC);
   localparam int unsigned NUM_WORDS = NUM_VEC / WORD_W;
   localparam int unsigned OFF_W     = $clog2(WORD_W);

   function automatic logic [OFF_W-1:0] top_bit(input logic [WORD_W-1:0] w);
      logic [OFF_W-1:0] r;
      r = '0;
      for (int b = 0; b < WORD_W; b++) begin
         if (w[b]) r = OFF_W'(b);
      end
      return r;
   endfunction

   logic [NUM_WORDS-1:0]            word_any;
   logic [NUM_WORDS-1:0][OFF_W-1:0] word_off;

   generate
      for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
         logic [WORD_W-1:0] slice;
         assign slice       = bits_i[w*WORD_W +: WORD_W];
         assign word_any[w] = |slice;
         assign word_off[w] = top_bit(slice);
      end
   endgenerate

   // Later (higher) words override earlier ones: top word wins
   always_comb begin
      found_o = |word_any;
      idx_o   = '0;
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (word_any[w]) idx_o = IDX_W'(w * WORD_W + int'(word_off[w]));
      end
   end

endmodule

// File: rtl/irq_bit_bank.sv
// One bit per vector with set and clear masks; the parameter picks the winner.
module irq_bit_bank #(
   parameter int unsigned NUM_VEC    = 256,
   parameter bit          CLEAR_WINS = 1'b0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_VEC-1:0] set_i,
   input  logic [NUM_VEC-1:0] clr_i,
   output logic [NUM_VEC-1:0] bits_o
);

   logic [NUM_VEC-1:0] bits_q;
   logic [NUM_VEC-1:0] bits_d;

   generate
      if (CLEAR_WINS) begin : g_clr_wins
         assign bits_d = (bits_q | set_i) & ~clr_i;
      end else begin : g_set_wins
         assign bits_d = (bits_q & ~clr_i) | set_i;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bits_q <= '0;
      else         bits_q <= bits_d;
   end

   assign bits_o = bits_q;

endmodule

// File: rtl/irq_prio_eval.sv
// Processor priority and deliverability of the top pending request.
module irq_prio_eval #(
   parameter int unsigned VEC_W   = 8,
   parameter int unsigned CLASS_W = 4
) (
   input  logic [VEC_W-1:0]   tpr_i,
   input  logic               isr_found_i,
   input  logic [CLASS_W-1:0] isr_cls_i,
   input  logic               irr_found_i,
   input  logic [CLASS_W-1:0] irr_cls_i,
   output logic               pending_o,
   output logic               deliver_o
);

   localparam int unsigned SUB_W = VEC_W - CLASS_W;

   logic [CLASS_W-1:0] svc_cls;
   logic [CLASS_W-1:0] tpr_cls;
   logic [CLASS_W-1:0] ppr_cls;
   logic [VEC_W-1:0]   ppr;

   assign svc_cls = isr_found_i ? isr_cls_i : '0;
   assign tpr_cls = tpr_i[VEC_W-1 -: CLASS_W];
   assign ppr     = (tpr_cls >= svc_cls) ? tpr_i : {svc_cls, {SUB_W{1'b0}}};
   assign ppr_cls = ppr[VEC_W-1 -: CLASS_W];

   assign pending_o = irr_found_i;
   assign deliver_o = irr_found_i && ((ppr == '0) || (irr_cls_i > ppr_cls));

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_prio_pkg::*;
#(
   parameter int unsigned VEC_W   = 8,
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned CLASS_W = 4
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               req_valid_i,
   input  logic [VEC_W-1:0]   req_vec_i,
   input  logic               req_level_i,
   input  logic               ack_i,
   output logic [VEC_W-1:0]   ack_vec_o,
   output logic               ack_none_o,
   input  logic               eoi_i,
   input  logic               eoi_suppress_i,
   input  logic               tpr_wr_i,
   input  logic [VEC_W-1:0]   tpr_wdata_i,
   input  logic               cr_wr_i,
   input  logic [CLASS_W-1:0] cr_wdata_i,
   output logic [CLASS_W-1:0] cr_rdata_o,
   input  logic               svr_wr_i,
   input  logic [VEC_W:0]     svr_wdata_i,
   output logic               irq_o,
   output logic               eoi_bcast_o,
   output logic [VEC_W-1:0]   eoi_bcast_vec_o
);

   localparam int unsigned NUM_VEC = 1 << VEC_W;
   localparam int unsigned SVR_W   = VEC_W + 1;
   localparam int unsigned SUB_W   = VEC_W - CLASS_W;

   generate
      if (CLASS_W < 1 || SUB_W < 1) begin : g_bad_class
         $error("irq_prio_ctrl: CLASS_W must be between 1 and VEC_W-1");
      end
      if (WORD_W < 2 || (NUM_VEC % WORD_W) != 0) begin : g_bad_word
         $error("irq_prio_ctrl: WORD_W must be at least 2 and divide the vector count");
      end
   endgenerate

   // ---------------- state ----------------
   logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
   logic [VEC_W-1:0]   tpr_q;
   logic [SVR_W-1:0]   svr_q;
   logic               irq_q;
   logic               bcast_q;
   logic [VEC_W-1:0]   bcast_vec_q;

   // ---------------- search ----------------
   logic               irr_found, isr_found, eoi_found;
   logic [VEC_W-1:0]   irr_top, isr_top, eoi_top;
   logic [NUM_VEC-1:0] isr_mid;

   irq_top_find #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_find_irr (
      .bits_i(irr_q), .found_o(irr_found), .idx_o(irr_top));
   irq_top_find #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_find_isr (
      .bits_i(isr_q), .found_o(isr_found), .idx_o(isr_top));
   irq_top_find #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_find_eoi (
      .bits_i(isr_mid), .found_o(eoi_found), .idx_o(eoi_top));

   // ---------------- priority ----------------
   logic pending, deliver, sw_en;

   irq_prio_eval #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) u_eval (
      .tpr_i       (tpr_q),
      .isr_found_i (isr_found),
      .isr_cls_i   (isr_top[VEC_W-1 -: CLASS_W]),
      .irr_found_i (irr_found),
      .irr_cls_i   (irr_top[VEC_W-1 -: CLASS_W]),
      .pending_o   (pending),
      .deliver_o   (deliver)
   );

   assign sw_en = svr_q[SVR_W-1];

   // ---------------- acknowledge ----------------
   ack_kind_e ack_kind;
   logic      grant;

   always_comb begin
      if (!sw_en || !pending) ack_kind = ACK_NONE;
      else if (deliver)       ack_kind = ACK_GRANT;
      else                    ack_kind = ACK_SPURIOUS;
   end

   always_comb begin
      unique case (ack_kind)
         ACK_GRANT:    ack_vec_o = irr_top;
         ACK_SPURIOUS: ack_vec_o = svr_q[VEC_W-1:0];
         default:      ack_vec_o = '0;
      endcase
   end

   assign ack_none_o = (ack_kind == ACK_NONE);
   assign grant      = ack_i && (ack_kind == ACK_GRANT);

   // ---------------- set/clear masks ----------------
   logic [NUM_VEC-1:0] req_mask, grant_mask, eoi_mask, lvl_set, lvl_clr;
   logic               eoi_fire;

   assign req_mask   = req_valid_i ? (NUM_VEC'(1) << req_vec_i) : '0;
   assign grant_mask = grant ? (NUM_VEC'(1) << irr_top) : '0;
   assign isr_mid    = isr_q | grant_mask;            // acknowledge first
   assign eoi_fire   = eoi_i && eoi_found;
   assign eoi_mask   = eoi_fire ? (NUM_VEC'(1) << eoi_top) : '0;
   assign lvl_set    = req_level_i ? req_mask : '0;
   assign lvl_clr    = req_level_i ? '0 : req_mask;

   irq_bit_bank #(.NUM_VEC(NUM_VEC), .CLEAR_WINS(1'b0)) u_irr (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(req_mask), .clr_i(grant_mask), .bits_o(irr_q));
   irq_bit_bank #(.NUM_VEC(NUM_VEC), .CLEAR_WINS(1'b1)) u_isr (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(grant_mask), .clr_i(eoi_mask), .bits_o(isr_q));
   irq_bit_bank #(.NUM_VEC(NUM_VEC), .CLEAR_WINS(1'b0)) u_tmr (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(lvl_set), .clr_i(lvl_clr), .bits_o(tmr_q));

   // ---------------- registers ----------------
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tpr_q <= '0;
      end else if (tpr_wr_i) begin
         tpr_q <= tpr_wdata_i;
      end else if (cr_wr_i) begin
         tpr_q <= {cr_wdata_i, {SUB_W{1'b0}}};
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       svr_q <= {1'b0, {VEC_W{1'b1}}};
      else if (svr_wr_i) svr_q <= svr_wdata_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         irq_q       <= 1'b0;
         bcast_q     <= 1'b0;
         bcast_vec_q <= '0;
      end else begin
         irq_q       <= sw_en && deliver;
         bcast_q     <= eoi_fire && tmr_q[eoi_top] && !eoi_suppress_i;
         bcast_vec_q <= eoi_fire ? eoi_top : '0;
      end
   end

   assign irq_o           = irq_q;
   assign eoi_bcast_o     = bcast_q;
   assign eoi_bcast_vec_o = bcast_vec_q;
   assign cr_rdata_o      = tpr_q[VEC_W-1 -: CLASS_W];

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
   parameter int unsigned VEC_W = 8
) (
   input logic                  clk_i,
   input logic                  rst_ni,
   input logic                  req_valid_i,
   input logic [VEC_W-1:0]      req_vec_i,
   input logic                  req_level_i,
   input logic                  ack_i,
   input logic [VEC_W-1:0]      ack_vec_o,
   input logic                  ack_none_o,
   input logic                  grant,
   input logic                  eoi_i,
   input logic                  eoi_suppress_i,
   input logic                  irq_o,
   input logic                  eoi_bcast_o,
   input logic [VEC_W-1:0]      eoi_bcast_vec_o,
   input logic                  sw_en,
   input logic                  isr_found,
   input logic [VEC_W-1:0]      isr_top,
   input logic [(1<<VEC_W)-1:0] irr_q,
   input logic [(1<<VEC_W)-1:0] isr_q,
   input logic [(1<<VEC_W)-1:0] tmr_q
);

   localparam int unsigned NUM_VEC = 1 << VEC_W;

   assert_req_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_i |=> irr_q[$past(req_vec_i)] && (tmr_q[$past(req_vec_i)] == $past(req_level_i)));

   assert_grant_moves_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant && !eoi_i && !req_valid_i |=> isr_q[$past(ack_vec_o)] && !irr_q[$past(ack_vec_o)]);

   assert_spurious_still_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_i && !ack_none_o && !grant && !req_valid_i && !eoi_i
      |=> (irr_q == $past(irr_q)) && (isr_q == $past(isr_q)));

   assert_eoi_clears_top_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      eoi_i && isr_found && !grant |=> !isr_q[$past(isr_top)]);

   assert_bcast_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      eoi_bcast_o |-> $past(eoi_i) && !$past(eoi_suppress_i)
                      && (($past(tmr_q) & (NUM_VEC'(1) << eoi_bcast_vec_o)) != '0));

   assert_irq_needs_enable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> $past(sw_en));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.VEC_W(VEC_W)) chk_i (
   .clk_i           (clk_i),
   .rst_ni          (rst_ni),
   .req_valid_i     (req_valid_i),
   .req_vec_i       (req_vec_i),
   .req_level_i     (req_level_i),
   .ack_i           (ack_i),
   .ack_vec_o       (ack_vec_o),
   .ack_none_o      (ack_none_o),
   .grant           (grant),
   .eoi_i           (eoi_i),
   .eoi_suppress_i  (eoi_suppress_i),
   .irq_o           (irq_o),
   .eoi_bcast_o     (eoi_bcast_o),
   .eoi_bcast_vec_o (eoi_bcast_vec_o),
   .sw_en           (sw_en),
   .isr_found       (isr_found),
   .isr_top         (isr_top),
   .irr_q           (irr_q),
   .isr_q           (isr_q),
   .tmr_q           (tmr_q)
);

// File: tb/irq_prio_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 0, req_level = 0, ack = 0, eoi = 0, eoi_sup = 0;
   logic [7:0] req_vec = 0, tpr_wdata = 0;
   logic       tpr_wr = 0, cr_wr = 0, svr_wr = 0;
   logic [3:0] cr_wdata = 0;
   logic [8:0] svr_wdata = 0;
   logic [7:0] ack_vec, bcast_vec;
   logic       ack_none, irq, bcast;
   logic [3:0] cr_rdata;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;   // 125 MHz

   irq_prio_ctrl dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .req_valid_i(req_valid), .req_vec_i(req_vec), .req_level_i(req_level),
      .ack_i(ack), .ack_vec_o(ack_vec), .ack_none_o(ack_none),
      .eoi_i(eoi), .eoi_suppress_i(eoi_sup),
      .tpr_wr_i(tpr_wr), .tpr_wdata_i(tpr_wdata),
      .cr_wr_i(cr_wr), .cr_wdata_i(cr_wdata), .cr_rdata_o(cr_rdata),
      .svr_wr_i(svr_wr), .svr_wdata_i(svr_wdata),
      .irq_o(irq), .eoi_bcast_o(bcast), .eoi_bcast_vec_o(bcast_vec)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic post_req(input int v, input bit lvl);
      req_valid = 1; req_vec = 8'(v); req_level = lvl;
      tick();
      req_valid = 0;
   endtask

   task automatic do_ack(output int v, output int none);
      ack = 1; #1;
      v = int'(ack_vec); none = int'(ack_none);
      tick();
      ack = 0;
   endtask

   task automatic do_eoi();
      eoi = 1; tick(); eoi = 0;
   endtask

   task automatic set_cr(input int n);
      cr_wr = 1; cr_wdata = 4'(n); tick(); cr_wr = 0;
   endtask

   task automatic set_tpr(input int n);
      tpr_wr = 1; tpr_wdata = 8'(n); tick(); tpr_wr = 0;
   endtask

   task automatic set_svr(input int n);
      svr_wr = 1; svr_wdata = 9'(n); tick(); svr_wr = 0;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      summary();
   end

   initial begin
      int v, none, hi, lo, a, b;
      bit exp;
      repeat (3) @(negedge clk);
      rst_n = 1;
      tick();

      // R1 reset state
      chk("R1 irq", int'(irq), 0);
      chk("R1 bcast", int'(bcast), 0);
      chk("R1 tpr", int'(cr_rdata), 0);
      ack = 1; #1;
      chk("R1 none flag", int'(ack_none), 1);
      chk("R1 none vector", int'(ack_vec), 0);
      ack = 0;
      post_req(8'h20, 0); tick();
      chk("R11 disabled after reset", int'(irq), 0);
      set_svr(9'h1FF); set_cr(4'hF); tick();
      do_ack(v, none);
      chk("R1 spurious reset value", v, 8'hFF);
      set_cr(0); tick();
      do_ack(v, none); chk("R7 grant", v, 8'h20);
      do_eoi(); chk("R10 edge no bcast", int'(bcast), 0);

      // R3 R5 R6 R7 R10: every vector through the full cycle
      for (int i = 0; i < 256; i++) begin
         post_req(i, i[0]);
         chk("R6 irq lags one cycle", int'(irq), 0);
         tick();
         chk("R5 irq with ppr zero", int'(irq), 1);
         do_ack(v, none);
         chk("R7 grant vector", v, i);
         chk("R7 grant not none", none, 0);
         tick();
         chk("R7 pending cleared", int'(irq), 0);
         do_eoi();
         chk("R10 bcast level only", int'(bcast), i % 2);
         if (i % 2 == 1) chk("R10 bcast vector", int'(bcast_vec), i);
         tick();
         chk("R10 one-cycle pulse", int'(bcast), 0);
      end

      // R3 two pending vectors, highest wins
      for (int k = 0; k < 15; k++) begin
         a = k * 16 + 2;
         b = (a + 17 * (k + 1)) % 256;
         hi = (a > b) ? a : b;
         lo = (a > b) ? b : a;
         post_req(a, 0); post_req(b, 1); tick();
         do_ack(v, none); chk("R3 highest first", v, hi);
         do_eoi(); chk("R10 bcast of hi", int'(bcast), (hi == b) ? 1 : 0);
         do_ack(v, none); chk("R3 lower next", v, lo);
         do_eoi(); chk("R10 bcast of lo", int'(bcast), (lo == b) ? 1 : 0);
      end

      // R4 R5 R8 R12: task class versus request class
      set_svr(9'h1C3);
      for (int t = 0; t < 16; t++) begin
         for (int c = 0; c < 16; c++) begin
            set_cr(t);
            chk("R12 4-bit readback", int'(cr_rdata), t);
            post_req(c * 16 + 5, 0); tick();
            exp = (t == 0) || (c > t);
            chk("R5 class gate", int'(irq), int'(exp));
            do_ack(v, none);
            if (exp) chk("R7 grant in grid", v, c * 16 + 5);
            else begin
               chk("R8 spurious vector", v, 8'hC3);
               chk("R8 spurious not none", none, 0);
               tick();
               chk("R8 still blocked", int'(irq), 0);
               set_cr(0); tick();
               chk("R8 request survived", int'(irq), 1);
               do_ack(v, none);
               chk("R8 vector after unblock", v, c * 16 + 5);
            end
            do_eoi();
         end
      end
      set_cr(0);

      // R4 in-service class masks same class
      post_req(8'h85, 1); tick();
      do_ack(v, none); chk("R7 grant 85", v, 8'h85);
      post_req(8'h83, 0); tick();
      chk("R4 same class blocked", int'(irq), 0);
      do_ack(v, none); chk("R8 spurious under isr", v, 8'hC3);
      post_req(8'h93, 0); tick();
      chk("R4 higher class passes", int'(irq), 1);
      do_ack(v, none); chk("R3 top is 93", v, 8'h93);
      do_eoi(); chk("R9 retire 93 edge", int'(bcast), 0);
      tick(); chk("R9 85 still in service", int'(irq), 0);
      do_eoi(); chk("R9 retire 85 level", int'(bcast), 1);
      chk("R10 vector 85", int'(bcast_vec), 8'h85);
      tick(); chk("R4 empty isr class 0", int'(irq), 1);
      do_ack(v, none); chk("R7 grant 83", v, 8'h83);
      do_eoi();

      // R4 R12 task priority above in-service class
      post_req(8'h41, 0); tick();
      do_ack(v, none); chk("R7 grant 41", v, 8'h41);
      set_tpr(8'h97);
      chk("R12 full write readback", int'(cr_rdata), 9);
      post_req(8'h95, 0); tick();
      chk("R4 ppr from tpr", int'(irq), 0);
      post_req(8'hA1, 0); tick();
      chk("R5 strictly above", int'(irq), 1);
      do_ack(v, none); chk("R7 grant A1", v, 8'hA1);
      do_eoi(); do_eoi();
      tpr_wr = 1; tpr_wdata = 8'h00; cr_wr = 1; cr_wdata = 4'h7; tick();
      tpr_wr = 0; cr_wr = 0;
      chk("R12 full write wins", int'(cr_rdata), 0);
      tick(); chk("R4 tpr cleared", int'(irq), 1);
      do_ack(v, none); chk("R7 grant 95", v, 8'h95);
      do_eoi();

      // R11 software enable
      post_req(8'h70, 0); tick();
      chk("R11 enabled", int'(irq), 1);
      set_svr(9'h0C3); tick();
      chk("R11 disabled irq", int'(irq), 0);
      do_ack(v, none);
      chk("R8 disabled none", none, 1);
      chk("R8 disabled vector", v, 0);
      set_svr(9'h1C3); tick();
      chk("R11 re-enabled", int'(irq), 1);
      do_ack(v, none); chk("R8 no state change", v, 8'h70);
      do_eoi();

      // R10 suppress control
      post_req(8'h52, 1); tick();
      do_ack(v, none);
      eoi_sup = 1; do_eoi(); eoi_sup = 0;
      chk("R10 suppressed", int'(bcast), 0);
      post_req(8'h51, 0); tick();
      chk("R9 suppressed eoi retired", int'(irq), 1);
      do_ack(v, none); chk("R7 grant 51", v, 8'h51);
      do_eoi();

      // R9 end-of-interrupt with empty in-service set
      set_cr(4'hF);
      post_req(8'h33, 1); tick();
      chk("R5 blocked by tpr", int'(irq), 0);
      do_eoi(); chk("R9 empty no bcast", int'(bcast), 0);
      set_cr(0); tick();
      chk("R9 pending untouched", int'(irq), 1);
      do_ack(v, none); chk("R9 vector kept", v, 8'h33);
      do_eoi(); chk("R10 bcast 33", int'(bcast_vec), 8'h33);

      // R13 acknowledge and end-of-interrupt together
      post_req(8'h40, 0); tick();
      do_ack(v, none);
      post_req(8'h66, 1); tick();
      chk("R5 66 over 40", int'(irq), 1);
      ack = 1; eoi = 1; #1;
      chk("R13 ack vector", int'(ack_vec), 8'h66);
      tick(); ack = 0; eoi = 0;
      chk("R13 bcast of granted", int'(bcast), 1);
      chk("R13 bcast vector", int'(bcast_vec), 8'h66);
      post_req(8'h45, 0); tick();
      chk("R13 40 still in service", int'(irq), 0);
      do_eoi(); chk("R13 retire 40", int'(bcast), 0);
      tick(); chk("R13 45 deliverable", int'(irq), 1);
      do_ack(v, none); do_eoi();

      // R2 latest request sets the trigger kind
      post_req(8'h7A, 1); post_req(8'h7A, 0);
      do_ack(v, none); do_eoi();
      chk("R2 edge overrides level", int'(bcast), 0);
      post_req(8'h7B, 0); post_req(8'h7B, 1);
      do_ack(v, none); do_eoi();
      chk("R2 level overrides edge", int'(bcast), 1);

      // R7 request in the same cycle as its grant stays pending
      post_req(8'h20, 0); tick();
      ack = 1; req_valid = 1; req_vec = 8'h20; req_level = 0; #1;
      chk("R7 grant 20", int'(ack_vec), 8'h20);
      tick(); ack = 0; req_valid = 0;
      do_ack(v, none);
      chk("R7 re-request pending", v, 8'hC3);
      do_eoi(); tick();
      chk("R7 re-request deliverable", int'(irq), 1);
      do_ack(v, none); chk("R7 re-request vector", v, 8'h20);
      do_eoi();

      summary();
   end

endmodule